// File: doc/BRIEF.md
# Type 1 to Type 0 Configuration Address Translator

This block sits on the downstream side of a bridge. It takes a Type 1 configuration request aimed at a device on the directly attached secondary bus and turns it into the 32-bit Type 0 address word for that bus. The device number becomes a single select line in the upper half of the word. The function and register numbers go in the lower half. Every access is a whole DWORD.

Each request is a one-cycle strobe on `req_valid`. One cycle later the block reports exactly one outcome:

- a translated address,
- a master-abort flag for a hidden device, or
- an unsupported-request flag when the extended register bits are non-zero.

The upstream logic turns the flags into its own completion status. The translated word is handed to the bus master.

Top module: `cfg_t1t0_xlate`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_ur`, `out_mabort` and `out_addr` are all zero.
- R2: A request sampled at a rising edge produces exactly one of `out_valid`, `out_ur`, `out_mabort` high for the single following cycle. Without a request all three are low and `out_addr` is zero.
- R3: For a translated request with device number N in 0..15, `out_addr[31:16]` has only bit 16+N set.
- R4: For a device number of 16 or more, the request is still translated (`out_valid`), but `out_addr[31:16]` is all zero.
- R5: In a translated word:
  - bits [1:0] are 2'b00;
  - bits [7:2] hold the register number;
  - bits [10:8] hold the function number;
  - bits [15:11] are zero.
- R6: With `hide_en` high and a device number in 0..9, the outcome is `out_mabort` and `out_addr` stays zero.
- R7: Device numbers 10..15 are translated whatever the value of `hide_en`.
- R8: Any non-zero `ext_reg` gives `out_ur` with `out_addr` zero. This overrides hiding and translation.
- R9: With `hide_en` low, device numbers 0..9 are translated normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| dev_num | input | 5 | Target device number |
| func_num | input | 3 | Function number |
| reg_num | input | 6 | DWORD register index within the 256-byte region |
| ext_reg | input | 4 | Extended register address bits above 256 bytes |
| hide_en | input | 1 | Device-hiding enable for devices 0..9 |
| out_valid | output | 1 | Translated address word valid (one cycle) |
| out_addr | output | 32 | Type 0 address word |
| out_ur | output | 1 | Unsupported-request outcome (one cycle) |
| out_mabort | output | 1 | Master-abort outcome (one cycle) |

## Verification
The assertions assume that the request fields and `hide_en` are settled whenever `req_valid` is sampled high. They sample the fields only in that cycle. They also assume the block is free to accept a request on every cycle, because there is no back-pressure.

The bench drives all inputs on the falling edge. It mixes idle gaps with back-to-back strobes. It changes the fields randomly even when no request is made, to show that idle inputs leave the outputs at zero.

// File: rtl/cfg_t1t0_xlate.sv
module cfg_t1t0_xlate #(
  parameter int DEV_W     = 5,
  parameter int FUNC_W    = 3,
  parameter int REG_W     = 6,
  parameter int EXT_W     = 4,
  parameter int IDSEL_LSB = 16,
  parameter int HIDE_LAST = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DEV_W-1:0]  dev_num,
  input  logic [FUNC_W-1:0] func_num,
  input  logic [REG_W-1:0]  reg_num,
  input  logic [EXT_W-1:0]  ext_reg,
  input  logic              hide_en,
  output logic              out_valid,
  output logic [31:0]       out_addr,
  output logic              out_ur,
  output logic              out_mabort
);
  localparam int IDSEL_N = 32 - IDSEL_LSB;
  localparam int PAD_W   = IDSEL_LSB - FUNC_W - REG_W - 2;

  logic                 ext_bad, in_range, hidden, take;
  logic [IDSEL_N-1:0]   idsel;
  logic [IDSEL_LSB-1:0] low_word;

  assign ext_bad  = |ext_reg;
  assign in_range = int'(dev_num) < IDSEL_N;
  assign hidden   = hide_en && (int'(dev_num) <= HIDE_LAST);
  assign take     = req_valid && !ext_bad && !hidden;
  assign idsel    = in_range ? (IDSEL_N'(1) << dev_num) : '0;
  assign low_word = {{PAD_W{1'b0}}, func_num, reg_num, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_ur     <= 1'b0;
      out_mabort <= 1'b0;
      out_addr   <= '0;
    end else begin
      out_valid  <= take;
      out_ur     <= req_valid && ext_bad;
      out_mabort <= req_valid && !ext_bad && hidden;
      out_addr   <= take ? {idsel, low_word} : '0;
    end
  end
endmodule

// File: rtl/cfg_t1t0_xlate_chk.sv
module cfg_t1t0_xlate_chk #(
  parameter int DEV_W     = 5,
  parameter int FUNC_W    = 3,
  parameter int REG_W     = 6,
  parameter int EXT_W     = 4,
  parameter int HIDE_LAST = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [DEV_W-1:0]  dev_num,
  input logic [FUNC_W-1:0] func_num,
  input logic [REG_W-1:0]  reg_num,
  input logic [EXT_W-1:0]  ext_reg,
  input logic              hide_en,
  input logic              out_valid,
  input logic [31:0]       out_addr,
  input logic              out_ur,
  input logic              out_mabort
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_ur && !out_mabort) || rst_n);

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_valid, out_ur, out_mabort}) <= 1);

  p_outcome_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_valid || out_ur || out_mabort));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_ur && !out_mabort && out_addr == 32'd0));

  p_idsel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_addr[31:16]) <= 1);

  p_type0_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[1:0] == 2'b00);

  p_hidden_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ext_reg == '0 && hide_en && int'(dev_num) <= HIDE_LAST)
      |=> (out_mabort && out_addr == 32'd0));

  p_never_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ext_reg == '0 && int'(dev_num) > HIDE_LAST && int'(dev_num) < 16)
      |=> out_valid);

  p_ext_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ext_reg != '0) |=> (out_ur && out_addr == 32'd0));
endmodule

bind cfg_t1t0_xlate cfg_t1t0_xlate_chk #(
  .DEV_W(DEV_W), .FUNC_W(FUNC_W), .REG_W(REG_W), .EXT_W(EXT_W), .HIDE_LAST(HIDE_LAST)
) u_chk (.*);

// File: tb/sim_cfg_t1t0_xlate.sv
module sim_cfg_t1t0_xlate;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, hide_en = 1'b0;
  logic [4:0]  dev_num = '0;
  logic [2:0]  func_num = '0;
  logic [5:0]  reg_num = '0;
  logic [3:0]  ext_reg = '0;
  logic        out_valid, out_ur, out_mabort;
  logic [31:0] out_addr;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic        e_v, e_ur, e_ma;
  logic [31:0] e_addr;
  string       e_tag;

  cfg_t1t0_xlate u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual v/ur/ma/addr=%b/%b/%b/%h expected %b/%b/%b/%h",
               tag, act[34], act[33], act[32], act[31:0], exp[34], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic model(input logic rv, input int d, input int f, input int r,
                       input int x, input logic h);
    e_v = 0; e_ur = 0; e_ma = 0; e_addr = 0; e_tag = "R2 idle";
    if (!rv) return;
    if (x != 0) begin e_ur = 1; e_tag = "R8 ext reject"; return; end
    if (h && d <= 9) begin e_ma = 1; e_tag = "R6 hidden"; return; end
    e_v = 1;
    e_addr = (f << 8) | (r << 2);
    if (d < 16) e_addr = e_addr | (32'd1 << (16 + d));
    if (d >= 16) e_tag = "R4 out of range";
    else if (d >= 10) e_tag = "R7 never hidden";
    else if (!h) e_tag = "R9 hiding off";
    else e_tag = "R3 idsel";
  endtask

  task automatic step(input logic rv, input int d, input int f, input int r,
                      input int x, input logic h);
    req_valid = rv; dev_num = 5'(d); func_num = 3'(f); reg_num = 6'(r);
    ext_reg = 4'(x); hide_en = h;
    model(rv, d, f, r, x, h);
    @(negedge clk);
    check(e_tag, {out_valid, out_ur, out_mabort, out_addr}, {e_v, e_ur, e_ma, e_addr});
    if (e_v) check("R5 low fields", {3'b000, 16'h0, out_addr[15:0]},
                   {3'b000, 16'h0, e_addr[15:0]});
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    req_valid = 1'b1; ext_reg = 4'h3;
    @(negedge clk);
    check("R1 reset", {out_valid, out_ur, out_mabort, out_addr}, 35'd0);
    req_valid = 1'b0; ext_reg = 0;
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 32; d++) step(1, d, d % 8, (d * 5) % 64, 0, 0);
    for (int d = 0; d < 32; d++) step(1, d, 7 - d % 8, 63 - d, 0, 1);
    for (int x = 1; x < 16; x++) step(1, x, 2, 9, x, x[0]);
    step(1, 3, 0, 0, 0, 1);
    step(1, 10, 7, 63, 0, 1);
    step(1, 15, 1, 1, 0, 1);
    step(1, 9, 5, 20, 0, 0);
    step(1, 9, 5, 20, 0, 1);
    for (int i = 0; i < 400; i++) begin
      bit rv = ($urandom % 3) != 0;
      int x = (($urandom % 5) == 0) ? int'($urandom % 16) : 0;
      step(rv, int'($urandom % 32), int'($urandom % 8), int'($urandom % 64), x,
           1'($urandom % 2));
    end
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule